// File: doc/BRIEF.md
# Manual Reset Input Conditioner

This block turns a raw, active-low manual reset input into a clean reset-request level for a downstream reset generator. The input may be driven by a bouncing mechanical switch or by a clean logic signal. It idles high through a pull-up that sits outside this logic. The raw level is first brought into the clock domain by a two-stage synchronizer. A press is then qualified by counting millisecond ticks while the input stays low, so short glitches and contact bounce are rejected and sustained presses are accepted.

Once a press is accepted, the request stays asserted for as long as the input is held low. After release it is stretched for a parameterized number of ticks, 250 by default. If the input drops low again during that stretch, the stretch starts over from the next release. The millisecond time base comes in as a one-cycle `tick_ms` strobe, so the same logic works at any clock frequency.

Top module: `pbrst_conditioner`

## Requirements
- R1: The synchronous active-high `rst` drives `rst_req` to 0 at the next clock edge, and `rst_req` reads 0 after reset.
- R2: While `btn_n` stays high, `rst_req` stays 0.
- R3: A low pulse on `btn_n` that covers fewer than PRESS_TICKS `tick_ms` strobes never raises `rst_req`. With the defaults, any pulse shorter than 3 tick periods (3 ms) is rejected.
- R4: A press is accepted only after the synchronized input has been sampled low on PRESS_TICKS consecutive ticks (default 4). Any high sample before then clears the count, so contact bounce with low intervals of at most one tick is rejected.
- R5: For a sustained low level, `rst_req` rises at least (PRESS_TICKS-1) and at most (PRESS_TICKS+1) tick periods after `btn_n` falls. With the defaults this is 3 to 5 ms, inside the 1 to 20 ms window.
- R6: After `btn_n` returns high, `rst_req` stays 1 for at least STRETCH_TICKS tick periods and falls within STRETCH_TICKS+2 tick periods.
- R7: If `btn_n` goes low again while the post-release stretch is running, the stretch restarts. `rst_req` then stays 1 for at least STRETCH_TICKS tick periods after the later release.
- R8: Once `rst_req` is 1, it stays 1 for as long as the synchronized input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle strobe once per millisecond |
| btn_n | input | 1 | Raw active-low manual reset level, idles high |
| rst_req | output | 1 | Registered reset request, active high |

## Verification
A press counter stuck above zero, or one that is not cleared by a high sample, shows up as a request that rises after bounce or a short glitch. The bench's per-clock reference model flags this within one clock of the edge where the request rises. A wrong stretch count or a missed restart shows up at the falling edge of `rst_req` after release, hundreds of ticks later. The latency and stretch-length measurements bound that edge to within one tick period. A stuck request-state bit shows up as `rst_req` failing to follow the model on the first clock after the divergence, because the output is compared on every clock.

// File: rtl/pbrst_pkg.sv
package pbrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HELD    = 2'd1,
    ST_RELEASE = 2'd2
  } stretch_state_e;
endpackage

// File: rtl/pbrst_sync2.sv
module pbrst_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/pbrst_press_qual.sv
module pbrst_press_qual #(
  parameter int PRESS_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic level_n,
  output logic press_ok
);
  localparam int CW = $clog2(PRESS_TICKS + 1);
  localparam logic [CW-1:0] CMAX = CW'(PRESS_TICKS);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (level_n) begin
      low_cnt <= '0;
    end else if (tick_ms && (low_cnt != CMAX)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign press_ok = (low_cnt == CMAX);

  // R4: acceptance only appears after a tick sampled with the input low
  a_r4_accept_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(press_ok) && !$past(rst)) |-> ($past(tick_ms) && !$past(level_n)));

  // R3: a high sample always withdraws acceptance on the next cycle
  a_r3_high_clears: assert property (@(posedge clk) disable iff (rst)
    level_n |=> !press_ok);
endmodule

// File: rtl/pbrst_release_stretch.sv
module pbrst_release_stretch
  import pbrst_pkg::*;
#(
  parameter int STRETCH_TICKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic level_n,
  input  logic press_ok,
  output logic rst_req
);
  localparam int SW = $clog2(STRETCH_TICKS + 1);
  localparam logic [SW-1:0] SMAX = SW'(STRETCH_TICKS);

  stretch_state_e state_q, state_d;
  logic [SW-1:0]  scnt_q, scnt_d;
  logic           req_q;

  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (press_ok) state_d = ST_HELD;
      end
      ST_HELD: begin
        if (level_n) begin
          state_d = ST_RELEASE;
          scnt_d  = '0;
        end
      end
      ST_RELEASE: begin
        if (!level_n) begin
          state_d = ST_HELD;
        end else if (tick_ms) begin
          if (scnt_q == SMAX) state_d = ST_IDLE;
          else                scnt_d  = scnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      req_q   <= (state_d != ST_IDLE);
    end
  end

  assign rst_req = req_q;

  // R6: the request only drops on a tick while the input is high
  a_r6_fall_on_tick_high: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_req) && !$past(rst)) |-> ($past(tick_ms) && $past(level_n)));
endmodule

// File: rtl/pbrst_conditioner.sv
module pbrst_conditioner #(
  parameter int PRESS_TICKS   = 4,
  parameter int STRETCH_TICKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic btn_n,
  output logic rst_req
);
  logic btn_s_n;
  logic press_ok;

  pbrst_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_n),
    .q_sync  (btn_s_n)
  );

  pbrst_press_qual #(.PRESS_TICKS(PRESS_TICKS)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .tick_ms  (tick_ms),
    .level_n  (btn_s_n),
    .press_ok (press_ok)
  );

  pbrst_release_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .tick_ms  (tick_ms),
    .level_n  (btn_s_n),
    .press_ok (press_ok),
    .rst_req  (rst_req)
  );

  // R4: a rising request always follows a qualified press
  a_r4_rise_needs_press: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_req) && !$past(rst)) |-> $past(press_ok));

  // R8: the request holds while the synchronized input is low
  a_r8_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !btn_s_n) |=> rst_req);
endmodule

// File: tb/tb_pbrst_conditioner.sv
module tb_pbrst_conditioner;
  localparam int P    = 4;
  localparam int S    = 250;
  localparam int TDIV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic btn_n = 1'b1;
  logic rst_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tdiv_cnt = 0;

  pbrst_conditioner #(.PRESS_TICKS(P), .STRETCH_TICKS(S)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .btn_n(btn_n), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  // tick source, driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tdiv_cnt == TDIV - 1) begin
      tdiv_cnt <= 0;
      tick_ms  <= 1'b1;
    end else begin
      tdiv_cnt <= tdiv_cnt + 1;
      tick_ms  <= 1'b0;
    end
  end

  // behavioural reference: delay queue plus integer tick counters
  bit m_q[$];
  int m_low_ticks = 0;
  int m_rel_ticks = 0;
  int m_mode = 0;   // 0 idle, 1 held, 2 releasing
  bit m_req = 1'b0;

  always @(posedge clk) begin
    bit s;
    int nlow;
    int nmode;
    int nrel;
    if (rst) begin
      m_q = '{1'b1, 1'b1};
      m_low_ticks = 0; m_rel_ticks = 0; m_mode = 0; m_req = 1'b0;
    end else begin
      s = m_q[0];
      nlow  = s ? 0 : ((tick_ms && m_low_ticks < P) ? m_low_ticks + 1 : m_low_ticks);
      nmode = m_mode;
      nrel  = m_rel_ticks;
      if (m_mode == 0) begin
        if (m_low_ticks == P) nmode = 1;
      end else if (m_mode == 1) begin
        if (s) begin nmode = 2; nrel = 0; end
      end else begin
        if (!s) nmode = 1;
        else if (tick_ms) begin
          if (m_rel_ticks == S) nmode = 0;
          else nrel = m_rel_ticks + 1;
        end
      end
      m_low_ticks = nlow; m_mode = nmode; m_rel_ticks = nrel;
      m_req = (nmode != 0);
      void'(m_q.pop_front());
      m_q.push_back(btn_n);
    end
  end

  // per-clock comparison against the model (R8 hold, R6/R7 stretch)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rst_req !== m_req) begin
        failures++;
        $display("FAIL R8 model compare cyc=%0d actual=%b expected=%b", cyc, rst_req, m_req);
      end
    end
  end

  task automatic chk(input string req, input bit cond, input int act, input int exp_v);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stay_low_checked(input int n, input string req);
    bit seen;
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (rst_req) seen = 1'b1;
    end
    chk(req, !seen, int'(seen), 0);
  endtask

  int t0;
  int d;

  initial begin : watchdog
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", rst_req == 1'b0, rst_req, 0);

    // R2: idle high
    stay_low_checked(200, "R2 idle high");

    // R3: short glitch covering at most 3 ticks
    btn_n = 1'b0; wait_cycles(25); btn_n = 1'b1;
    stay_low_checked(80, "R3 short glitch");
    btn_n = 1'b0; wait_cycles(3); btn_n = 1'b1;
    stay_low_checked(40, "R3 very short pulse");

    // R4: bounce, low intervals of 7 cycles, high of 3
    for (int i = 0; i < 30; i++) begin
      btn_n = 1'b0; wait_cycles(7);
      btn_n = 1'b1; wait_cycles(3);
    end
    stay_low_checked(60, "R4 bounce rejected");

    // R5: latency of a sustained press
    btn_n = 1'b0; t0 = cyc;
    while (!rst_req && (cyc - t0) < 400) @(negedge clk);
    d = cyc - t0;
    chk("R5 latency min", d >= (P - 1) * TDIV, d, (P - 1) * TDIV);
    chk("R5 latency max", d <= (P + 1) * TDIV, d, (P + 1) * TDIV);

    // R8: hold while low
    wait_cycles(300);
    chk("R8 held while low", rst_req == 1'b1, rst_req, 1);

    // R6: stretch after release
    btn_n = 1'b1; t0 = cyc;
    while (rst_req && (cyc - t0) < 5000) @(negedge clk);
    d = cyc - t0;
    chk("R6 stretch min", d >= S * TDIV, d, S * TDIV);
    chk("R6 stretch max", d <= (S + 2) * TDIV, d, (S + 2) * TDIV);
    wait_cycles(30);
    chk("R6 stays released", rst_req == 1'b0, rst_req, 0);

    // R7: re-press mid-stretch restarts it
    btn_n = 1'b0; wait_cycles(80); btn_n = 1'b1;
    wait_cycles(100 * TDIV);
    btn_n = 1'b0; wait_cycles(5); btn_n = 1'b1; t0 = cyc;
    while (rst_req && (cyc - t0) < 5000) @(negedge clk);
    d = cyc - t0;
    chk("R7 restart min", d >= S * TDIV, d, S * TDIV);
    chk("R7 restart max", d <= (S + 2) * TDIV, d, (S + 2) * TDIV);

    // R1: reset while asserted
    btn_n = 1'b0; wait_cycles(80);
    chk("R5 asserted before reset", rst_req == 1'b1, rst_req, 1);
    rst = 1'b1; @(negedge clk);
    chk("R1 reset clears request", rst_req == 1'b0, rst_req, 0);
    btn_n = 1'b1; wait_cycles(3); rst = 1'b0;
    stay_low_checked(50, "R1 quiet after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule